// File: doc/BRIEF.md
# Bus Access Violation Capture Unit

This block sits beside a set of protected slave ports and records the illegal accesses that an upstream policy checker reports. Each report arrives as a single-cycle pulse that carries the slave index, the master ID, the domain ID, the direction and a 36-bit address. The block sets one status bit for each offending slave. It raises a single level interrupt while any status bit that is not masked is set.

Slaves are split into equal shift groups. Each group latches the full details of its first violation and holds them until software clears that group's pending bit. To read the details, software selects a group with a one-hot value and starts a transfer. After a fixed delay the transfer copies the stored details into two debug words and reports completion through the transfer-control register. Software polls that register, reads the debug words, stops the transfer and then clears the group.

Top module: `vio_capture`

## Requirements
- R1: After reset, irq_o is 0. Every mask bit reads 1, every status bit reads 0, the control register reads 0, and the group-pending and transfer-control registers read 0.
- R2: While the unit is enabled, a violation on slave i sets bit i%32 of status word i/32 (byte offset 0x100 + 4*(i/32)). Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R3: Mask word i/32 (offset 0x000 + 4*(i/32)) bit i%32 masks slave i. irq_o goes high one cycle after a status bit whose mask bit is 0 becomes set, and it stays low while every set status bit is masked.
- R4: A write to the control register (0x300) disables the unit when wdata bit 2 is 1, and otherwise enables it when bit 31 is 1. Disable takes priority when both bits are 1. The control register reads bit 31 as the enable state. While the unit is disabled, violation pulses change neither status nor group-pending bits.
- R5: Group g covers slaves g*S to g*S+S-1, where S is slaves divided by groups. The group-pending register (0x310) bit g is set by a violation in group g, and writing 1 to that bit clears it.
- R6: A group keeps only the details of the violation that set its pending bit. Later violations in the same group still set status bits but do not replace the stored details.
- R7: The group select register (0x314) holds a one-hot value, and the lowest set bit selects the group. Writing 1 to transfer-control (0x318) starts a transfer, and the register then reads 0x1 for 8 cycles. After that it reads 0x3 and the debug words hold the selected group's details. Writing 0 returns the register to 0x0.
- R8: Debug word 0 (0x200) holds the master ID in bits [15:0] and the domain ID in [21:16]. Bit 22 is set for a write and bit 23 for a read. Bits [27:24] hold address bits [35:32], and bits [31:28] read 0. Debug word 1 (0x204) holds address bits [31:0].
- R9: Addresses outside the register map read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 10 | Byte address of the register access |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| vio_valid_i | input | 1 | Violation report pulse |
| vio_slave_i | input | 6 | Index of the offending slave |
| vio_master_i | input | 16 | Master ID of the offending access |
| vio_domain_i | input | 6 | Domain ID of the offending access |
| vio_write_i | input | 1 | 1 for a write access, 0 for a read |
| vio_addr_i | input | 36 | Address of the offending access |
| irq_o | output | 1 | Violation interrupt, active high |

## Verification
The assertions assume that vio_slave_i is below the slave count whenever vio_valid_i is high, that the group select holds at most one set bit when a transfer starts, and that software does not write 1 to transfer-control in the same cycle as a group clear. The stimulus reports violations only on valid slave indices, writes only one-hot or two-bit select values, and keeps register writes one cycle apart from violation pulses. Any two-bit select value is there on purpose, to exercise the lowest-bit priority.

// File: rtl/vio_pkg.sv
package vio_pkg;
  localparam int ADDR_W = 10;

  localparam logic [ADDR_W-1:0] OFS_DBG0 = 10'h200;
  localparam logic [ADDR_W-1:0] OFS_DBG1 = 10'h204;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 10'h300;
  localparam logic [ADDR_W-1:0] OFS_GSTA = 10'h310;
  localparam logic [ADDR_W-1:0] OFS_GSEL = 10'h314;
  localparam logic [ADDR_W-1:0] OFS_GCON = 10'h318;
  localparam logic [1:0]        RGN_MASK = 2'd0;
  localparam logic [1:0]        RGN_STA  = 2'd1;

  typedef struct packed {
    logic [15:0] master;
    logic [5:0]  domain;
    logic        wr;
    logic [35:0] addr;
  } vio_rec_t;

  // state encoding equals the transfer-control readback code
  typedef enum logic [1:0] {
    SH_IDLE = 2'b00,
    SH_BUSY = 2'b01,
    SH_DONE = 2'b11
  } sh_state_e;
endpackage

// File: rtl/vio_status_bank.sv
module vio_status_bank #(
  parameter int N_SLV = 64,
  parameter int NREG  = (N_SLV + 31) / 32,
  parameter int IDXW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SLV-1:0] set_i,
  input  logic             mask_we_i,
  input  logic             sta_clr_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic [31:0]      wdata_i,
  output logic [N_SLV-1:0] sta_o,
  output logic [N_SLV-1:0] mask_o,
  output logic             irq_o
);
  for (genvar i = 0; i < N_SLV; i++) begin : g_bit
    localparam int RI = i / 32;
    localparam int BI = i % 32;
    logic sel;
    assign sel = (idx_i == IDXW'(RI));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[i] <= 1'b1;
        sta_o[i]  <= 1'b0;
      end else begin
        if (mask_we_i && sel) mask_o[i] <= wdata_i[BI];
        if (set_i[i])                              sta_o[i] <= 1'b1;
        else if (sta_clr_i && sel && wdata_i[BI])  sta_o[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(sta_o & ~mask_o);
  end
endmodule

// File: rtl/vio_group_store.sv
module vio_group_store
  import vio_pkg::*;
#(
  parameter int N_GRP = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_GRP-1:0]       hit_i,
  input  logic [N_GRP-1:0]       clr_i,
  input  vio_rec_t               rec_i,
  output logic [N_GRP-1:0]       pend_o,
  output vio_rec_t [N_GRP-1:0]   rec_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic keep;
    assign keep = pend_o[g] & ~clr_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[g] <= 1'b0;
        rec_o[g]  <= '0;
      end else begin
        pend_o[g] <= keep | hit_i[g];
        if (hit_i[g] && !keep) rec_o[g] <= rec_i;
      end
    end
  end
endmodule

// File: rtl/vio_shift_seq.sv
module vio_shift_seq
  import vio_pkg::*;
#(
  parameter int N_GRP     = 4,
  parameter int SHIFT_CYC = 8,
  parameter int CW        = $clog2(SHIFT_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [N_GRP-1:0]     sel_i,
  input  vio_rec_t [N_GRP-1:0] rec_i,
  output sh_state_e            state_o,
  output logic [31:0]          dbg0_o,
  output logic [31:0]          dbg1_o
);
  logic [N_GRP-1:0] sel_q;
  logic [CW-1:0]    cnt_q;
  vio_rec_t         pick;
  logic             found;

  // lowest selected group wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      if (sel_q[g]) begin
        pick  = rec_i[g];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= SH_IDLE;
      sel_q   <= '0;
      cnt_q   <= '0;
      dbg0_o  <= '0;
      dbg1_o  <= '0;
    end else if (stop_i) begin
      state_o <= SH_IDLE;
    end else begin
      unique case (state_o)
        SH_IDLE: if (start_i) begin
          state_o <= SH_BUSY;
          sel_q   <= sel_i;
          cnt_q   <= '0;
        end
        SH_BUSY: begin
          if (cnt_q == CW'(SHIFT_CYC - 1)) begin
            state_o <= SH_DONE;
            if (found) begin
              dbg0_o <= {4'b0, pick.addr[35:32], ~pick.wr, pick.wr,
                         pick.domain, pick.master};
              dbg1_o <= pick.addr[31:0];
            end else begin
              dbg0_o <= '0;
              dbg1_o <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_o <= SH_DONE;
      endcase
    end
  end
endmodule

// File: rtl/vio_capture.sv
module vio_capture
  import vio_pkg::*;
#(
  parameter int N_SLV     = 64,
  parameter int N_GRP     = 4,
  parameter int SHIFT_CYC = 8,
  parameter int SLV_W     = $clog2(N_SLV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              vio_valid_i,
  input  logic [SLV_W-1:0]  vio_slave_i,
  input  logic [15:0]       vio_master_i,
  input  logic [5:0]        vio_domain_i,
  input  logic              vio_write_i,
  input  logic [35:0]       vio_addr_i,
  output logic              irq_o
);
  localparam int NREG = (N_SLV + 31) / 32;
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int SPG  = N_SLV / N_GRP;

  logic                 en_q;
  logic [N_GRP-1:0]     gsel_q;
  logic [N_SLV-1:0]     sta_vec, mask_vec, slv_set;
  logic [N_GRP-1:0]     grp_hit, grp_clr, grp_pend;
  vio_rec_t [N_GRP-1:0] grp_rec;
  vio_rec_t             in_rec;
  sh_state_e            sh_state;
  logic [31:0]          dbg0, dbg1;
  logic [1:0]           rgn;
  logic [IDXW-1:0]      ridx;
  logic                 in_rng, live;
  logic                 wr_mask, wr_sta, wr_ctrl, wr_gsta, wr_gsel, wr_gcon;
  logic [NREG*32-1:0]   sta_pad, mask_pad;

  assign rgn    = reg_addr_i[9:8];
  assign ridx   = reg_addr_i[2 +: IDXW];
  assign in_rng = ({2'b0, reg_addr_i[7:2]} < 8'(NREG));

  assign wr_mask = reg_we_i && rgn == RGN_MASK && in_rng;
  assign wr_sta  = reg_we_i && rgn == RGN_STA && in_rng;
  assign wr_ctrl = reg_we_i && reg_addr_i == OFS_CTRL;
  assign wr_gsta = reg_we_i && reg_addr_i == OFS_GSTA;
  assign wr_gsel = reg_we_i && reg_addr_i == OFS_GSEL;
  assign wr_gcon = reg_we_i && reg_addr_i == OFS_GCON;

  assign live = vio_valid_i && en_q;

  always_comb begin
    slv_set = '0;
    if (live) slv_set[vio_slave_i] = 1'b1;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_hit
    assign grp_hit[g] = live && (int'(vio_slave_i) / SPG == g);
    assign grp_clr[g] = wr_gsta && reg_wdata_i[g];
  end

  assign in_rec = '{master: vio_master_i, domain: vio_domain_i,
                    wr: vio_write_i, addr: vio_addr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      gsel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        if (reg_wdata_i[2])       en_q <= 1'b0;
        else if (reg_wdata_i[31]) en_q <= 1'b1;
      end
      if (wr_gsel) gsel_q <= reg_wdata_i[N_GRP-1:0];
    end
  end

  vio_status_bank #(.N_SLV(N_SLV), .NREG(NREG), .IDXW(IDXW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (slv_set),
    .mask_we_i (wr_mask),
    .sta_clr_i (wr_sta),
    .idx_i     (ridx),
    .wdata_i   (reg_wdata_i),
    .sta_o     (sta_vec),
    .mask_o    (mask_vec),
    .irq_o     (irq_o)
  );

  vio_group_store #(.N_GRP(N_GRP)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (grp_hit),
    .clr_i  (grp_clr),
    .rec_i  (in_rec),
    .pend_o (grp_pend),
    .rec_o  (grp_rec)
  );

  vio_shift_seq #(.N_GRP(N_GRP), .SHIFT_CYC(SHIFT_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_gcon && reg_wdata_i[0]),
    .stop_i  (wr_gcon && !reg_wdata_i[0]),
    .sel_i   (gsel_q),
    .rec_i   (grp_rec),
    .state_o (sh_state),
    .dbg0_o  (dbg0),
    .dbg1_o  (dbg1)
  );

  assign sta_pad  = (NREG * 32)'(sta_vec);
  assign mask_pad = (NREG * 32)'(mask_vec);

  always_comb begin
    reg_rdata_o = '0;
    if (rgn == RGN_MASK && in_rng)     reg_rdata_o = mask_pad[ridx*32 +: 32];
    else if (rgn == RGN_STA && in_rng) reg_rdata_o = sta_pad[ridx*32 +: 32];
    else begin
      unique case (reg_addr_i)
        OFS_DBG0: reg_rdata_o = dbg0;
        OFS_DBG1: reg_rdata_o = dbg1;
        OFS_CTRL: reg_rdata_o = {en_q, 31'b0};
        OFS_GSTA: reg_rdata_o = 32'(grp_pend);
        OFS_GSEL: reg_rdata_o = 32'(gsel_q);
        OFS_GCON: reg_rdata_o = {30'b0, sh_state};
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vio_capture_chk.sv
module vio_capture_chk #(
  parameter int N_SLV = 64,
  parameter int N_GRP = 4,
  parameter int REC_W = 59
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         irq_o,
  input logic                         en_q,
  input logic [N_SLV-1:0]             sta_vec,
  input logic [N_SLV-1:0]             mask_vec,
  input logic [N_GRP-1:0]             grp_pend,
  input logic [N_GRP-1:0]             grp_clr,
  input logic [N_GRP-1:0][REC_W-1:0]  grp_rec,
  input logic [1:0]                   sh_state,
  input logic                         wr_gcon,
  input logic [31:0]                  dbg0
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(sta_vec & ~mask_vec))); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sta_vec & ~mask_vec)) |=> irq_o); // R3
  AST_OFF_NO_NEW_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> ((sta_vec & ~$past(sta_vec)) == '0)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_state == 2'b11 && !wr_gcon) |=> sh_state == 2'b11); // R7
  AST_DBG_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dbg0) |-> (sh_state == 2'b11 && $past(sh_state) == 2'b01)); // R7

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    AST_FIRST_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_pend[g] && $past(grp_pend[g] && !grp_clr[g])) |-> $stable(grp_rec[g])); // R6
  end
endmodule

bind vio_capture vio_capture_chk #(.N_SLV(N_SLV), .N_GRP(N_GRP)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .sta_vec  (sta_vec),
  .mask_vec (mask_vec),
  .grp_pend (grp_pend),
  .grp_clr  (grp_clr),
  .grp_rec  (grp_rec),
  .sh_state (sh_state),
  .wr_gcon  (wr_gcon),
  .dbg0     (dbg0)
);

// File: tb/vio_capture_bench.sv
`timescale 1ns/1ps
module vio_capture_bench;
  localparam logic [9:0] A_MASK0 = 10'h000, A_MASK1 = 10'h004;
  localparam logic [9:0] A_STA0 = 10'h100, A_STA1 = 10'h104;
  localparam logic [9:0] A_DBG0 = 10'h200, A_DBG1 = 10'h204;
  localparam logic [9:0] A_CTRL = 10'h300, A_GSTA = 10'h310;
  localparam logic [9:0] A_GSEL = 10'h314, A_GCON = 10'h318;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vio_valid = 1'b0;
  logic [5:0]  vio_slave = '0;
  logic [15:0] vio_master = '0;
  logic [5:0]  vio_domain = '0;
  logic        vio_write = 1'b0;
  logic [35:0] vio_addr = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t exp_q[$];
  bit    mon_pend = 1'b0;

  always #10 clk = ~clk;

  vio_capture u_vio_capture (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_addr_i   (reg_addr),
    .reg_we_i     (reg_we),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .vio_valid_i  (vio_valid),
    .vio_slave_i  (vio_slave),
    .vio_master_i (vio_master),
    .vio_domain_i (vio_domain),
    .vio_write_i  (vio_write),
    .vio_addr_i   (vio_addr),
    .irq_o        (irq)
  );

  // monitor: pop expected items and compare against outputs
  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : reg_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #1;
    reg_addr = a;
    exp_q.push_back('{is_irq: 1'b0, exp: e, req: req});
    mon_pend = 1'b1;
    @(posedge clk); #1;
    mon_pend = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string req);
    @(posedge clk); #1;
    exp_q.push_back('{is_irq: 1'b1, exp: {31'b0, e}, req: req});
    mon_pend = 1'b1;
    @(posedge clk); #1;
    mon_pend = 1'b0;
  endtask

  task automatic vio(input logic [5:0] s, input logic [15:0] m, input logic [5:0] d,
                     input logic w, input logic [35:0] a);
    @(posedge clk); #1;
    vio_valid = 1'b1; vio_slave = s; vio_master = m;
    vio_domain = d; vio_write = w; vio_addr = a;
    @(posedge clk); #1;
    vio_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      reg_addr = A_GCON;
      @(negedge clk);
      if (reg_rdata == 32'h3) break;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    irq_chk(1'b0, "R1 irq after reset");
    rd_chk(A_MASK0, 32'hFFFF_FFFF, "R1 mask word 0");
    rd_chk(A_MASK1, 32'hFFFF_FFFF, "R1 mask word 1");
    rd_chk(A_STA0, 32'h0, "R1 status word 0");
    rd_chk(A_CTRL, 32'h0, "R1 control");
    rd_chk(A_GSTA, 32'h0, "R1 group pending");
    rd_chk(A_GCON, 32'h0, "R1 transfer control");

    vio(6'd5, 16'h1234, 6'h01, 1'b1, 36'h0_0000_0010);
    rd_chk(A_STA0, 32'h0, "R4 disabled status unchanged");
    rd_chk(A_GSTA, 32'h0, "R4 disabled group unchanged");

    wr(A_CTRL, 32'h8000_0000);
    rd_chk(A_CTRL, 32'h8000_0000, "R4 enable");

    vio(6'd37, 16'hBEEF, 6'h2A, 1'b1, 36'h9_1234_5678);
    rd_chk(A_STA1, 32'h0000_0020, "R2 slave 37 -> word 1 bit 5");
    rd_chk(A_GSTA, 32'h4, "R5 group 2 pending");
    irq_chk(1'b0, "R3 masked slave no irq");

    wr(A_MASK1, 32'h0);
    irq_chk(1'b1, "R3 unmasked irq");

    vio(6'd40, 16'h1111, 6'h05, 1'b0, 36'h1_AAAA_BBBB);
    rd_chk(A_STA1, 32'h0000_0120, "R2 second slave in word 1");
    rd_chk(A_GSTA, 32'h4, "R5 still group 2 only");

    wr(A_STA1, 32'h0);
    rd_chk(A_STA1, 32'h0000_0120, "R2 write 0 no effect");
    wr(A_STA1, 32'h0000_0020);
    rd_chk(A_STA1, 32'h0000_0100, "R2 write-one clear");

    wr(A_GSEL, 32'h4);
    wr(A_GCON, 32'h1);
    rd_chk(A_GCON, 32'h1, "R7 busy after start");
    wait_done();
    rd_chk(A_GCON, 32'h3, "R7 completion code");
    rd_chk(A_DBG0, 32'h096A_BEEF, "R6 R8 first record word 0");
    rd_chk(A_DBG1, 32'h1234_5678, "R8 address low word");
    wr(A_GCON, 32'h0);
    rd_chk(A_GCON, 32'h0, "R7 stop");
    wr(A_GSTA, 32'h4);
    rd_chk(A_GSTA, 32'h0, "R5 group clear");

    vio(6'd3, 16'h0042, 6'h3F, 1'b0, 36'hF_0000_0001);
    rd_chk(A_GSTA, 32'h1, "R5 group 0 pending");
    wr(A_GSEL, 32'h5);
    wr(A_GCON, 32'h1);
    wait_done();
    rd_chk(A_DBG0, 32'h0FBF_0042, "R7 R8 lowest group, read flag");
    rd_chk(A_DBG1, 32'h0000_0001, "R8 address low word group 0");
    wr(A_GCON, 32'h0);

    irq_chk(1'b1, "R3 irq from slave 40");
    wr(A_STA1, 32'h0000_0100);
    irq_chk(1'b0, "R3 irq drops with masked slave 3 pending");

    wr(A_CTRL, 32'h8000_0004);
    rd_chk(A_CTRL, 32'h0, "R4 disable wins");
    vio(6'd10, 16'h7777, 6'h02, 1'b1, 36'h0_0000_0100);
    rd_chk(A_STA0, 32'h0000_0008, "R4 disabled, status unchanged");

    rd_chk(10'h3FC, 32'h0, "R9 unmapped reads zero");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule